// File: doc/BRIEF.md
# Ramped Binary Rate Multiplier

This block produces a train of single-cycle output pulses whose average rate is N/16 of the clock, where N is a 4-bit rate word. A free-running 4-bit counter decodes four disjoint one-cycle strobes at the /2, /4, /8 and /16 rates. Each strobe is gated by one bit of the rate word, and the gated strobes are ORed into a registered output. The pulses are unevenly spaced, but every 16-cycle period carries exactly N of them.

The rate word is not loaded from outside. It is held in a saturating up/down ramp counter. The counter moves by one on each cycle in which the step enable is high. A small two-state machine holds the ramp direction. State `DIR_UP` (entered at reset) goes to `DIR_DOWN` whenever the direction input changes level. State `DIR_DOWN` goes back to `DIR_UP` on the next level change. With no change the machine stays in its state, so the ramp keeps the direction it last had. Only edges of the direction input matter, not its level. Everything runs on a single clock, and the slow ramp is paced only by the step enable.

Top module: `ramp_rate_mult`

## Requirements
- R1: While reset is high, `rate_word` is 0 and `pulse_out` is 0 from the following clock edge on. The ramp direction is set to up. The level of `dir_in` at reset is taken as the reference level, so a first step after reset raises the rate from 0 to 1.
- R2: The divider runs freely with a 16-cycle period. The count is 0 in the cycle right after reset is released, and in every 16th cycle after that. The value on `rate_word` during that cycle is captured and used for the whole period. Ramp moves later in the period do not change that period's pulses.
- R3: The weighted strobes never coincide: rate bit 3 gates the strobe at count values with bit0=1, bit 2 gates count bits[1:0]=10, bit 1 gates bits[2:0]=100, and bit 0 gates bits[3:0]=1000. The output is registered one cycle behind the strobe. Each period therefore produces exactly N pulses, seen in the 16 cycles from divider count 2 up to count 1 of the next period.
- R4: A captured rate of 0 gives no pulses in that period, and a captured rate of 15 gives 15 pulses.
- R5: With `step_en` low, `rate_word` keeps its value, whatever `dir_in` does.
- R6: With `step_en` high, `rate_word` changes by exactly one at the next clock edge, up in `DIR_UP` and down in `DIR_DOWN`.
- R7: Counting up stops at 15 and counting down stops at 0. The rate word never wraps.
- R8: Any change of level on `dir_in` (rising or falling) reverses the direction. A step taken in the same cycle as the change already uses the new direction. The reversal persists until the next level change, whether or not steps happen in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst | input | 1 | Synchronous reset, active high |
| dir_in | input | 1 | Direction control; each level change reverses the ramp |
| step_en | input | 1 | Moves the ramp counter one step when high |
| rate_word | output | 4 | Current ramp counter value (rate N) |
| pulse_out | output | 1 | Registered rate-multiplied pulse train |

## Verification
The bench counts output pulses over each 16-cycle window and compares the count with the rate word seen at the start of that period. If the capture point were wrong, or the strobes overlapped and merged under the OR, the counts would drift from N. The bench drives the ramp into both ends and holds it there, so a counter that wraps would show 0 after 15 or 15 after 0. It toggles `dir_in` with the step enable low and then steps, so a design that follows the level instead of edges, or that applies a reversal one cycle late, would step the wrong way. A reset applied while `dir_in` is high checks that no false reversal follows reset.

// File: rtl/rrm_pkg.sv
package rrm_pkg;

    // Ramp direction state
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } ramp_dir_e;

endpackage

// File: rtl/rrm_divider.sv
module rrm_divider #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    output logic         start,
    output logic [W-1:0] tap
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign start = (cnt_q == '0);

    // tap[k]: lowest k+1 count bits equal a one followed by k zeros
    for (genvar k = 0; k < W; k++) begin : g_tap
        localparam logic [W-1:0] PAT = ONE << k;
        assign tap[k] = (cnt_q[k:0] == PAT[k:0]);
    end

    // R3
    taps_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tap));

endmodule

// File: rtl/rrm_ramp.sv
module rrm_ramp
    import rrm_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dir_in,
    input  logic         step_en,
    output logic [W-1:0] rate
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] BOT = '0;
    localparam logic [W-1:0] ONE = W'(1);

    ramp_dir_e    state_q, state_d;
    logic         prev_q;
    logic         flip;
    logic [W-1:0] rate_q, rate_d;

    assign flip = dir_in ^ prev_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DIR_UP;
            prev_q  <= dir_in;
            rate_q  <= '0;
        end else begin
            state_q <= state_d;
            prev_q  <= dir_in;
            rate_q  <= rate_d;
        end
    end

    // Next-state: a level change on dir_in reverses
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DIR_UP:   if (flip) state_d = DIR_DOWN;
            DIR_DOWN: if (flip) state_d = DIR_UP;
        endcase
    end

    // Output: saturating step in the effective direction
    always_comb begin
        rate_d = rate_q;
        if (step_en) begin
            unique case (state_d)
                DIR_UP:   if (rate_q != TOP) rate_d = rate_q + ONE;
                DIR_DOWN: if (rate_q != BOT) rate_d = rate_q - ONE;
            endcase
        end
    end

    assign rate = rate_q;

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(rate_q));

    // R6
    unit_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rate_q) |-> (rate_q == $past(rate_q) + ONE) || (rate_q == $past(rate_q) - ONE));

    // R7
    no_wrap_top_chk: assert property (@(posedge clk) disable iff (rst)
        rate_q == TOP |=> rate_q != BOT);

    // R7
    no_wrap_bot_chk: assert property (@(posedge clk) disable iff (rst)
        rate_q == BOT |=> rate_q != TOP);

    // R8
    reverse_on_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        flip && step_en && state_q == DIR_UP && rate_q != BOT |=> rate_q == $past(rate_q) - ONE);

endmodule

// File: rtl/rrm_gate.sv
module rrm_gate #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] tap,
    input  logic [W-1:0] rate,
    output logic         pulse
);
    logic [W-1:0] rate_l;
    logic [W-1:0] term;
    logic         pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_l  <= '0;
            pulse_q <= 1'b0;
        end else begin
            if (start) rate_l <= rate;
            pulse_q <= |term;
        end
    end

    // Fastest strobe weighted by the rate MSB, slowest by the LSB
    for (genvar k = 0; k < W; k++) begin : g_term
        assign term[k] = tap[k] & rate_l[W-1-k];
    end

    assign pulse = pulse_q;

    // R2
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(rate_l));

    // R4
    zero_rate_silent_chk: assert property (@(posedge clk) disable iff (rst)
        rate_l == '0 |=> !pulse_q);

endmodule

// File: rtl/ramp_rate_mult.sv
module ramp_rate_mult #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dir_in,
    input  logic         step_en,
    output logic [W-1:0] rate_word,
    output logic         pulse_out
);
    logic         start;
    logic [W-1:0] tap;

    rrm_divider #(.W(W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .tap   (tap)
    );

    rrm_ramp #(.W(W)) u_ramp (
        .clk     (clk),
        .rst     (rst),
        .dir_in  (dir_in),
        .step_en (step_en),
        .rate    (rate_word)
    );

    rrm_gate #(.W(W)) u_gate (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .tap   (tap),
        .rate  (rate_word),
        .pulse (pulse_out)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (rate_word == '0) && !pulse_out);

endmodule

// File: tb/ramp_rate_mult_tb.sv
`timescale 1ns/1ps
module ramp_rate_mult_tb;
    localparam int W = 4;
    localparam int MAXV = 15;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         dir_in = 1'b0;
    logic         step_en = 1'b0;
    logic [W-1:0] rate_word;
    logic         pulse_out;

    ramp_rate_mult #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .dir_in(dir_in), .step_en(step_en),
        .rate_word(rate_word), .pulse_out(pulse_out)
    );

    always #4 clk = ~clk;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Bench model of the ramp and window bookkeeping
    int m_rate;
    bit m_down;
    bit m_prev;
    int ph;
    int acc;
    int cur_exp;
    int pend;
    bit have_exp;

    function automatic void check(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endfunction

    function automatic int step_model(int r, bit down);
        if (!down) return (r < MAXV) ? r + 1 : r;
        return (r > 0) ? r - 1 : r;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        step_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 rate_word at reset", int'(rate_word), 0);
        check("R1 pulse_out at reset", int'(pulse_out), 0);
        m_rate = 0;
        m_down = 1'b0;
        m_prev = dir_in;
        rst = 1'b0;
        ph = 0;
        acc = 0;
        have_exp = 0;
        pend = int'(rate_word);
    endtask

    // One clock: inputs already set; sample at the following negedge
    task automatic tick();
        bit eff;
        @(posedge clk);
        eff = m_down ^ (dir_in != m_prev);
        if (step_en) m_rate = step_model(m_rate, eff);
        m_down = eff;
        m_prev = dir_in;
        @(negedge clk);
        ph = (ph + 1) % 16;
        check(cur_req, int'(rate_word), m_rate);
        acc += int'(pulse_out);
        if (ph == 0) pend = int'(rate_word);
        if (ph == 1) begin
            if (have_exp) begin
                if (cur_exp == 0 || cur_exp == MAXV)
                    check("R4 pulses per period", acc, cur_exp);
                else
                    check("R2/R3 pulses per period", acc, cur_exp);
            end
            acc = 0;
            cur_exp = pend;
            have_exp = 1;
        end
    endtask

    task automatic run(int n, bit st);
        step_en = st;
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_2A17));
        @(negedge clk);
        do_reset();

        cur_req = "R1 first step goes up";
        run(1, 1'b1);
        cur_req = "R6 ramp up";
        run(5, 1'b1);
        cur_req = "R7 saturate at 15";
        run(20, 1'b1);
        cur_req = "R5 hold at 15";
        run(48, 1'b0);

        cur_req = "R8 rising edge reverses";
        dir_in = 1'b1;
        run(1, 1'b1);
        cur_req = "R8 direction persists";
        run(4, 1'b1);
        cur_req = "R7 saturate at 0";
        run(20, 1'b1);
        cur_req = "R5 hold at 0";
        run(48, 1'b0);

        cur_req = "R5 toggle without step";
        dir_in = 1'b0;
        run(3, 1'b0);
        cur_req = "R8 reversal kept for later step";
        run(3, 1'b1);
        cur_req = "R5 double toggle without step";
        dir_in = 1'b1;
        run(1, 1'b0);
        dir_in = 1'b0;
        run(2, 1'b0);
        cur_req = "R8 falling edge reverses";
        run(2, 1'b1);

        cur_req = "R6 random ramp";
        for (int i = 0; i < 2500; i++) begin
            step_en = (($urandom % 4) == 0);
            if (($urandom % 16) == 0) dir_in = ~dir_in;
            tick();
        end

        dir_in = 1'b1;
        @(negedge clk);
        do_reset();
        cur_req = "R1 no false reversal after reset";
        run(2, 1'b1);

        cur_req = "R6 random ramp after reset";
        for (int i = 0; i < 600; i++) begin
            step_en = (($urandom % 3) == 0);
            if (($urandom % 12) == 0) dir_in = ~dir_in;
            tick();
        end
        run(40, 1'b0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule